// File: doc/BRIEF.md
# Transfer Event Timestamp Unit

This block times a 32-bit streaming loopback test. The host first sends a programmed number of 4096-byte sectors toward the device, and only after that reads the same amount back. One 48-bit counter starts at reset and runs freely. The block copies its value when four events happen: the first accepted upload word, the last accepted upload word, the first sent download word and the last sent download word. Any interval between two events is then the unsigned difference of the two stamps.

The block gets no end-of-transfer signal. It counts valid words in each direction and compares the count with sectors × 1024. A start pulse arms the block, latches the sector count and clears every capture. A small state machine then moves from armed to upload, to download, and to done. A strobe that arrives in the wrong phase is dropped and raises a sticky error flag.

Top module: `xfer_stamp_unit`

## Requirements
- R1: A 48-bit counter reads 0 in the cycle after a reset cycle and adds 1 on every clock. A stamp holds the counter value of the cycle in which its qualifying strobe is sampled.
- R2: A start pulse with a nonzero `sector_cnt` arms the block. It latches the count and clears all four stamps, `done` and `proto_err` to 0. Strobes sampled in that cycle are ignored. A start pulse with `sector_cnt` = 0 has no effect.
- R3: The first `up_valid` sampled after arming is captured into `ts_up_first`.
- R4: Upload word number n×1024 is captured into `ts_up_last` and ends the upload phase. Here n is the latched sector count and words are numbered from 1. Until that word arrives, `ts_up_last` stays 0.
- R5: In the download phase, the first `dn_valid` is captured into `ts_dn_first`. Word n×1024 is captured into `ts_dn_last`, and `done` rises in the next cycle and stays high until the next arm.
- R6: Each stamp is written at most once per armed test. Later strobes leave it unchanged.
- R7: Some strobes are ignored: `up_valid` outside the armed or upload phase, and `dn_valid` outside the download phase (idle and done included). Such a strobe changes no stamp and sets `proto_err`, which stays set until the next arm.
- R8: `up_elapsed` = `ts_up_last` − `ts_up_first`, `dn_elapsed` = `ts_dn_last` − `ts_dn_first`, and `total_elapsed` = `ts_dn_last` − `ts_up_first`. All three are unsigned 48-bit values.
- R9: After reset, all stamps and differences are 0 and `done` and `proto_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Arm pulse; clears the captures |
| sector_cnt | input | 18 | Number of 4096-byte sectors per direction |
| up_valid | input | 1 | One upload word accepted this cycle |
| dn_valid | input | 1 | One download word sent this cycle |
| ts_up_first | output | 48 | Stamp of the first upload word |
| ts_up_last | output | 48 | Stamp of the last upload word |
| ts_dn_first | output | 48 | Stamp of the first download word |
| ts_dn_last | output | 48 | Stamp of the last download word |
| up_elapsed | output | 48 | Upload duration |
| dn_elapsed | output | 48 | Download duration |
| total_elapsed | output | 48 | First upload word to last download word |
| done | output | 1 | Test complete |
| proto_err | output | 1 | Sticky wrong-phase strobe flag |

## Verification
The tests use sector counts of one to three, and random idle gaps between words give timestamps that are not evenly spaced. An error-free run and a run with a download strobe injected during the upload show whether wrong-phase strobes are counted as words or only flagged. The bench checks the last-upload stamp one word before the boundary, which exposes an off-by-one in the word limit. Strobes after done, in idle, and during a start with a zero sector count show whether the stamps are truly write-once and whether the arm is qualified correctly.

// File: rtl/xfs_pkg.sv
// Shared types for the transfer event timestamp unit.
// Assumes: only the phase encoding is shared between modules.
package xfs_pkg;
    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_ARMED    = 3'd1,
        ST_UPLOAD   = 3'd2,
        ST_DOWNLOAD = 3'd3,
        ST_DONE     = 3'd4
    } xfs_state_e;
endpackage

// File: rtl/xfs_free_counter.sv
// Free-running time base; every stamp is a copy of this value.
// Assumes: WIDTH is large enough that the count never wraps during a test.
module xfs_free_counter #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [WIDTH-1:0] q
);
    // Increment on every clock; return to zero on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= q + 1'b1;
    end

    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (q == $past(q) + 1'b1)); // R1
endmodule

// File: rtl/xfs_word_tracker.sv
// Counts the words moved in one direction and flags the first and last word
// positions. Assumes last_idx stays constant while the block is armed.
module xfs_word_tracker #(
    parameter int CNT_W = 28
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             step,
    input  logic [CNT_W-1:0] last_idx,
    output logic             at_first,
    output logic             at_last
);
    logic [CNT_W-1:0] count;

    // Word count since the last arm; it advances on each accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) count <= '0;
        else if (step)     count <= count + 1'b1;
    end

    // Compare the count of words already moved with the edges of the test.
    always_comb begin
        at_first = (count == '0);
        at_last  = (count == last_idx);
    end
endmodule

// File: rtl/xfs_stamp_reg.sv
// A capture-once timestamp register. It copies d on the first cap after a
// clear and then holds that value. Assumes clr has priority over cap.
module xfs_stamp_reg #(
    parameter int WIDTH = 48
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             cap,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic held;

    // Take the first capture after a clear, then lock.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            q    <= '0;
            held <= 1'b0;
        end else if (cap && !held) begin
            q    <= d;
            held <= 1'b1;
        end
    end

    AST_STAMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (held && !clr) |=> $stable(q)); // R6
endmodule

// File: rtl/xfer_stamp_unit.sv
// Transfer event timestamp unit. It stamps the first and last word of the
// upload and download phases of a loopback test against one free-running
// counter, and gives the elapsed times as differences.
// Assumes: all upload words come before any download word; the sector count
// is held stable only at the start pulse (it is latched there).
module xfer_stamp_unit #(
    parameter int TS_W   = 48,
    parameter int SEC_W  = 18,
    parameter int WORD_L = 10
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic [SEC_W-1:0] sector_cnt,
    input  logic            up_valid,
    input  logic            dn_valid,
    output logic [TS_W-1:0] ts_up_first,
    output logic [TS_W-1:0] ts_up_last,
    output logic [TS_W-1:0] ts_dn_first,
    output logic [TS_W-1:0] ts_dn_last,
    output logic [TS_W-1:0] up_elapsed,
    output logic [TS_W-1:0] dn_elapsed,
    output logic [TS_W-1:0] total_elapsed,
    output logic            done,
    output logic            proto_err
);
    import xfs_pkg::*;

    localparam int CNT_W = SEC_W + WORD_L;
    localparam int NDIR  = 2;   // index 0 = upload, 1 = download

    xfs_state_e       state;
    logic [SEC_W-1:0] n_lat;
    logic [CNT_W-1:0] last_idx;
    logic [TS_W-1:0]  now;
    logic             arm, up_ok, dn_ok, up_acc, dn_acc, bad;
    logic [NDIR-1:0]  step, at_first, at_last;
    logic [TS_W-1:0]  stamp [4];
    logic [3:0]       cap;

    xfs_free_counter #(.WIDTH(TS_W)) u_time (
        .clk(clk), .rst_n(rst_n), .q(now)
    );

    // Qualify the strobes by phase; the arm pulse masks them.
    always_comb begin
        arm    = start && (sector_cnt != '0);
        up_ok  = (state == ST_ARMED) || (state == ST_UPLOAD);
        dn_ok  = (state == ST_DOWNLOAD);
        up_acc = !arm && up_valid && up_ok;
        dn_acc = !arm && dn_valid && dn_ok;
        bad    = !arm && ((up_valid && !up_ok) || (dn_valid && !dn_ok));
        step   = {dn_acc, up_acc};
    end

    // Index of the final word: n * words_per_sector - 1.
    always_comb last_idx = {n_lat, {WORD_L{1'b0}}} - 1'b1;

    // Latch the sector count when the block is armed.
    always_ff @(posedge clk) begin
        if (!rst_n)   n_lat <= '0;
        else if (arm) n_lat <= sector_cnt;
    end

    genvar gd;
    generate
        for (gd = 0; gd < NDIR; gd++) begin : g_dir
            xfs_word_tracker #(.CNT_W(CNT_W)) u_trk (
                .clk(clk), .rst_n(rst_n), .clr(arm), .step(step[gd]),
                .last_idx(last_idx), .at_first(at_first[gd]), .at_last(at_last[gd])
            );
        end
    endgenerate

    // Capture strobes: order is up-first, up-last, dn-first, dn-last.
    always_comb begin
        cap[0] = up_acc && at_first[0];
        cap[1] = up_acc && at_last[0];
        cap[2] = dn_acc && at_first[1];
        cap[3] = dn_acc && at_last[1];
    end

    genvar gs;
    generate
        for (gs = 0; gs < 4; gs++) begin : g_stamp
            xfs_stamp_reg #(.WIDTH(TS_W)) u_stamp (
                .clk(clk), .rst_n(rst_n), .clr(arm), .cap(cap[gs]),
                .d(now), .q(stamp[gs])
            );
        end
    endgenerate

    // Phase sequencing: armed, then upload, then download, then done.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else if (arm) begin
            state <= ST_ARMED;
        end else begin
            unique case (state)
                ST_ARMED:    if (up_acc) state <= at_last[0] ? ST_DOWNLOAD : ST_UPLOAD;
                ST_UPLOAD:   if (up_acc && at_last[0]) state <= ST_DOWNLOAD;
                ST_DOWNLOAD: if (dn_acc && at_last[1]) state <= ST_DONE;
                default:     state <= state;
            endcase
        end
    end

    // Sticky flag for wrong-phase strobes; cleared on arm.
    always_ff @(posedge clk) begin
        if (!rst_n || arm) proto_err <= 1'b0;
        else if (bad)      proto_err <= 1'b1;
    end

    // Drive the outputs and the unsigned differences.
    always_comb begin
        ts_up_first   = stamp[0];
        ts_up_last    = stamp[1];
        ts_dn_first   = stamp[2];
        ts_dn_last    = stamp[3];
        up_elapsed    = stamp[1] - stamp[0];
        dn_elapsed    = stamp[3] - stamp[2];
        total_elapsed = stamp[3] - stamp[0];
        done          = (state == ST_DONE);
    end

    AST_ARM_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        arm |=> (!done && !proto_err && ts_up_first == '0 && ts_dn_last == '0)); // R2
    AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !arm) |=> done); // R5
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (proto_err && !arm) |=> proto_err); // R7
    AST_PHASE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ts_dn_first > ts_up_last && ts_up_last >= ts_up_first)); // R5
    AST_BAD_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && dn_valid && state == ST_UPLOAD) |=> (proto_err && ts_dn_first == '0)); // R7
endmodule

// File: tb/xfer_stamp_unit_bench.sv
// Self-checking bench: random gaps and sector counts, plus directed corners.
module xfer_stamp_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [17:0] sector_cnt = '0;
    logic        up_valid = 1'b0;
    logic        dn_valid = 1'b0;
    logic [47:0] ts_up_first, ts_up_last, ts_dn_first, ts_dn_last;
    logic [47:0] up_elapsed, dn_elapsed, total_elapsed;
    logic        done, proto_err;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [47:0] ref_time;

    xfer_stamp_unit u_xfer_stamp_unit (
        .clk(clk), .rst_n(rst_n), .start(start), .sector_cnt(sector_cnt),
        .up_valid(up_valid), .dn_valid(dn_valid),
        .ts_up_first(ts_up_first), .ts_up_last(ts_up_last),
        .ts_dn_first(ts_dn_first), .ts_dn_last(ts_dn_last),
        .up_elapsed(up_elapsed), .dn_elapsed(dn_elapsed),
        .total_elapsed(total_elapsed), .done(done), .proto_err(proto_err)
    );

    always #5 clk = ~clk;

    // Bench time base, following the R1 counter definition.
    always @(posedge clk) begin
        if (!rst_n) ref_time <= '0;
        else        ref_time <= ref_time + 48'd1;
    end

    function automatic logic [47:0] diff(input logic [47:0] a, input logic [47:0] b);
        return a - b;
    endfunction

    task automatic chk(input string req, input logic [47:0] act, input logic [47:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive one strobe for one cycle and return the expected stamp value.
    task automatic strobe(input bit up, output logic [47:0] ts);
        repeat ($urandom % 3) @(negedge clk);
        if (up) up_valid = 1'b1; else dn_valid = 1'b1;
        ts = ref_time;
        @(negedge clk);
        up_valid = 1'b0;
        dn_valid = 1'b0;
    endtask

    task automatic arm(input logic [17:0] n);
        sector_cnt = n;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic run_test(input int n, input bit inject);
        logic [47:0] t, uf, ul, df, dl;
        int words;
        words = n * 1024;
        uf = '0; ul = '0; df = '0; dl = '0;
        arm(18'(n));
        chk("R2 stamps cleared", ts_up_first | ts_dn_last, 48'd0);
        chk("R2 flags cleared", {46'd0, done, proto_err}, 48'd0);
        for (int w = 0; w < words; w++) begin
            strobe(1'b1, t);
            if (w == 0) uf = t;
            if (w == words - 1) ul = t;
            if (w == words - 2) chk("R4 last not yet captured", ts_up_last, 48'd0);
            if (inject && w == 5) begin
                strobe(1'b0, t);
                chk("R7 download strobe in upload flags", {47'd0, proto_err}, 48'd1);
                chk("R7 download strobe in upload ignored", ts_dn_first, 48'd0);
            end
        end
        chk("R3 first upload stamp", ts_up_first, uf);
        chk("R4 last upload stamp", ts_up_last, ul);
        chk("R5 not done after upload", {47'd0, done}, 48'd0);
        for (int w = 0; w < words; w++) begin
            strobe(1'b0, t);
            if (w == 0) df = t;
            if (w == words - 1) dl = t;
        end
        chk("R5 first download stamp", ts_dn_first, df);
        chk("R5 last download stamp", ts_dn_last, dl);
        chk("R5 done", {47'd0, done}, 48'd1);
        chk("R8 upload elapsed", up_elapsed, diff(ul, uf));
        chk("R8 download elapsed", dn_elapsed, diff(dl, df));
        chk("R8 total elapsed", total_elapsed, diff(dl, uf));
        chk("R7 error only when injected", {47'd0, proto_err}, {47'd0, inject});
        strobe(1'b0, t);
        strobe(1'b1, t);
        chk("R6 up first held after done", ts_up_first, uf);
        chk("R6 dn last held after done", ts_dn_last, dl);
        chk("R7 strobes after done flag", {47'd0, proto_err}, 48'd1);
        chk("R5 done stays", {47'd0, done}, 48'd1);
    endtask

    initial begin
        logic [47:0] t;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R9 reset stamps", ts_up_first | ts_up_last | ts_dn_first | ts_dn_last, 48'd0);
        chk("R9 reset differences", up_elapsed | dn_elapsed | total_elapsed, 48'd0);
        chk("R9 reset flags", {46'd0, done, proto_err}, 48'd0);
        strobe(1'b1, t);
        chk("R7 idle strobe flags", {47'd0, proto_err}, 48'd1);
        chk("R7 idle strobe ignored", ts_up_first, 48'd0);
        arm(18'd0);
        chk("R2 zero-sector start ignored", {47'd0, proto_err}, 48'd1);
        sector_cnt = 18'd1;
        up_valid = 1'b1;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        up_valid = 1'b0;
        chk("R2 strobe on arm cycle ignored", ts_up_first, 48'd0);
        chk("R2 arm clears error", {47'd0, proto_err}, 48'd0);
        strobe(1'b0, t);
        chk("R7 download strobe while armed flags", {47'd0, proto_err}, 48'd1);
        chk("R7 download strobe while armed ignored", ts_dn_first, 48'd0);
        run_test(1, 1'b0);
        run_test(1 + int'($urandom % 3), 1'b1);
        run_test(3, 1'b0);
        repeat (2) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule